// File: doc/BRIEF.md
# Active-Low Serial Link Transceiver

This block is the physical engine of a two-wire master link made of a clock line and one shared data line. The data line runs through an external level translator whose direction the block sets. Both directions of the data line are active low: a logical 1 is a low level on the wire. On a start request the block latches a command frame and clocks it out most-significant bit first, behind a start bit. It then holds the line idle for a fixed echo window and turns the translator around to receive.

In receive, the block keeps clocking the link and watches for the slave's start bit, giving up after a bounded number of bit periods. After a start bit it captures a two-bit slave identifier and a two-bit response tag. Data bytes follow only for an acknowledge tag when the caller asked for data. A four-bit CRC closes the response and is checked over everything received. Frame construction and any retry policy belong to the layer above. That layer supplies a frame with its length and the number of data bytes expected, and reads back the tag, data, CRC verdict and timeout flag when `done` pulses.

Top module: `sline_xcvr`

## Requirements
- R1: Out of reset and whenever no transaction runs, `link_clk` is 1, `link_dir` is 1 (driving), `link_dat_o` is 1 (idle wire level) and `done` is 0. After reset `rsp_tag`, `rsp_data`, `crc_err` and `timeout` are 0.
- R2: A bit period is 2*HALF cycles, with `link_clk` low for the first HALF cycles and high for the rest. The cycle after `start` is sampled high in idle begins the start bit, a wire 0. It is followed by bits `tx_len-1` down to 0 of `tx_frame`, each sent inverted (wire = NOT bit).
- R3: After the last frame bit the line is driven at wire 1 for ECHO_BITS (16) bit periods. `link_dir` then drops to 0 for the whole receive phase and returns to 1 only in the `done` cycle.
- R4: In receive, the wire passes through a two-flop synchronizer and is captured in the last cycle of each bit period. The slave changes the wire after `link_clk` falls. The first captured wire 0 is the response start bit.
- R5: If none of WAIT_MAX (1000) consecutive receive bit periods holds a start bit, `done` pulses with `timeout`=1 and `rsp_tag`, `rsp_data` and `crc_err` at 0. A start bit in period 1000 is still accepted.
- R6: The 4 bits after the start bit are the slave identifier, then the tag, MSB first. The tag is presented on `rsp_tag`; tag 0 means acknowledge.
- R7: Only when the tag is 0 and `rx_bytes` is nonzero are `rx_bytes`*8 data bits captured, MSB first and right-aligned in `rsp_data`. Otherwise no data bits are taken and `rsp_data` is 0.
- R8: The CRC uses the generator x^4+x^2+x+1 and starts at 0. It runs MSB first over the start bit, identifier, tag, any data and the 4 received CRC bits. A nonzero remainder sets `crc_err`.
- R9: `done` is a one-cycle pulse in the cycle after the last receive bit period. Results are valid there and held until the next accepted `start`.
- R10: `start` while a transaction runs is ignored: the link waveform and results of the running transaction are unchanged.
- R11: With `tx_len` 0 only the start bit is sent before the echo window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken in idle only) |
| tx_frame | input | FRAME_W | Command frame, right-aligned |
| tx_len | input | LEN_W | Number of frame bits to send |
| rx_bytes | input | BYT_W | Data bytes expected with an acknowledge |
| link_clk | output | 1 | Link clock |
| link_dat_o | output | 1 | Wire level driven on the data line |
| link_dat_i | input | 1 | Wire level seen on the data line |
| link_dir | output | 1 | Translator direction, 1 = drive, 0 = receive |
| done | output | 1 | One-cycle completion pulse |
| rsp_tag | output | 2 | Response tag |
| rsp_data | output | DATA_W | Response data, right-aligned |
| crc_err | output | 1 | Response CRC check failed |
| timeout | output | 1 | No response start bit seen |

## Verification
The bench aims at the receive-window edge. A start bit in the thousandth period must be taken, and a silent slave must time out after exactly that many periods. An off-by-one wait counter would either report a timeout on a valid response or wait one period too long. A busy tag with data requested, and an acknowledge with zero bytes, check that the receive length follows the tag. A design that always clocked data in would overrun into the CRC and flag a false error. A corrupted CRC bit, a zero-length frame and a start pulse injected mid-transaction expose a checker that skips bits, a shifter that sends a phantom bit, and a controller that restarts while busy.

// File: rtl/sline_pkg.sv
package sline_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TXS, ST_TXB, ST_ECHO, ST_WAIT, ST_HDR, ST_DAT, ST_CRC, ST_DONE
  } st_e;

  // generator x^4 + x^2 + x + 1, top term implied
  localparam logic [3:0] CRC_POLY = 4'h7;

  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? CRC_POLY : 4'h0);
  endfunction

  // active-low line: logical value to wire level and back
  function automatic logic to_wire(input logic b);
    return ~b;
  endfunction

endpackage

// File: rtl/sline_bitclk.sv
module sline_bitclk #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic lclk,
  output logic bit_end
);
  localparam int PER = 2 * HALF;
  localparam int PW  = (PER > 2) ? $clog2(PER) : 1;

  logic [PW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ph <= '0;
    else if (!run)                ph <= '0;
    else if (ph == PW'(PER - 1))  ph <= '0;
    else                          ph <= ph + 1'b1;
  end

  assign lclk    = !run || (ph >= PW'(HALF));
  assign bit_end = run && (ph == PW'(PER - 1));
endmodule

// File: rtl/sline_sync2.sv
module sline_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      q  <= 1'b1;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/sline_crc4.sv
module sline_crc4 import sline_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [3:0] nxt
);
  logic [3:0] crc_r;
  assign nxt = crc4_step(crc_r, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_r <= '0;
    else if (clr) crc_r <= '0;
    else if (en)  crc_r <= nxt;
  end
endmodule

// File: rtl/sline_xcvr.sv
module sline_xcvr import sline_pkg::*; #(
  parameter  int FRAME_W    = 64,
  parameter  int DATA_BYTES = 4,
  parameter  int HALF       = 2,
  parameter  int ECHO_BITS  = 16,
  parameter  int WAIT_MAX   = 1000,
  localparam int LEN_W      = $clog2(FRAME_W + 1),
  localparam int DATA_W     = 8 * DATA_BYTES,
  localparam int BYT_W      = $clog2(DATA_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FRAME_W-1:0] tx_frame,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [BYT_W-1:0]  rx_bytes,
  output logic              link_clk,
  output logic              link_dat_o,
  input  logic              link_dat_i,
  output logic              link_dir,
  output logic              done,
  output logic [1:0]        rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              crc_err,
  output logic              timeout
);
  localparam int CNT_W = $clog2(WAIT_MAX + FRAME_W + DATA_W + ECHO_BITS + 1);

  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [FRAME_W-1:0] frame_q;
  logic [LEN_W-1:0]  len_q;
  logic [BYT_W-1:0]  bytes_q;
  logic [1:0]        tag_q;
  logic [DATA_W-1:0] data_q;
  logic              crc_err_q, to_q;

  // named internal events (used by the bound checker)
  logic       bit_end, run, line_s, rx_bit, acc, idle_w, in_wait, rx_phase;
  logic       crc_en;
  logic [1:0] hdr_tag;
  logic [3:0] crc_nx;

  assign idle_w   = (st == ST_IDLE);
  assign acc      = idle_w && start;
  assign run      = !(st == ST_IDLE || st == ST_DONE);
  assign in_wait  = (st == ST_WAIT);
  assign rx_phase = (st == ST_WAIT) || (st == ST_HDR) || (st == ST_DAT) || (st == ST_CRC);
  assign rx_bit   = to_wire(line_s);        // undo active-low on receive (R4)
  assign hdr_tag  = {tag_q[0], rx_bit};
  assign crc_en   = bit_end && ((in_wait && rx_bit) || st == ST_HDR ||
                                st == ST_DAT || st == ST_CRC);

  sline_bitclk #(.HALF(HALF)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run(run), .lclk(link_clk), .bit_end(bit_end)
  );

  sline_sync2 u_sync (.clk(clk), .rst_n(rst_n), .d(link_dat_i), .q(line_s));

  sline_crc4 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(acc), .en(crc_en), .din(rx_bit), .nxt(crc_nx)
  );

  // line drive (R1 idle, R2 start/frame, R3 echo and turnaround)
  always_comb begin
    link_dir   = !rx_phase;
    link_dat_o = 1'b1;
    case (st)
      ST_TXS:  link_dat_o = to_wire(1'b1);
      ST_TXB:  link_dat_o = to_wire(frame_q[cnt]);
      default: link_dat_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; frame_q <= '0; len_q <= '0; bytes_q <= '0;
      tag_q <= '0; data_q <= '0; crc_err_q <= 1'b0; to_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin                     // R10: only here
          frame_q <= tx_frame; len_q <= tx_len; bytes_q <= rx_bytes;
          tag_q <= '0; data_q <= '0; crc_err_q <= 1'b0; to_q <= 1'b0;
          st <= ST_TXS;
        end
        ST_TXS: if (bit_end) begin
          if (len_q == '0) begin                      // R11
            st <= ST_ECHO; cnt <= CNT_W'(ECHO_BITS - 1);
          end else begin
            st <= ST_TXB; cnt <= CNT_W'(len_q) - CNT_W'(1);
          end
        end
        ST_TXB: if (bit_end) begin
          if (cnt == '0) begin
            st <= ST_ECHO; cnt <= CNT_W'(ECHO_BITS - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_ECHO: if (bit_end) begin
          if (cnt == '0) begin st <= ST_WAIT; cnt <= '0; end
          else cnt <= cnt - 1'b1;
        end
        ST_WAIT: if (bit_end) begin                   // R4, R5
          if (rx_bit) begin
            st <= ST_HDR; cnt <= CNT_W'(3);
          end else if (cnt == CNT_W'(WAIT_MAX - 1)) begin
            st <= ST_DONE; to_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_HDR: if (bit_end) begin                    // R6
          tag_q <= hdr_tag;
          if (cnt == '0) begin
            if (hdr_tag == 2'd0 && bytes_q != '0) begin  // R7
              st <= ST_DAT; cnt <= (CNT_W'(bytes_q) << 3) - CNT_W'(1);
            end else begin
              st <= ST_CRC; cnt <= CNT_W'(3);
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_DAT: if (bit_end) begin
          data_q <= {data_q[DATA_W-2:0], rx_bit};
          if (cnt == '0) begin st <= ST_CRC; cnt <= CNT_W'(3); end
          else cnt <= cnt - 1'b1;
        end
        ST_CRC: if (bit_end) begin                    // R8
          if (cnt == '0) begin
            st <= ST_DONE; crc_err_q <= (crc_nx != 4'h0);
          end else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;                       // ST_DONE: R9
      endcase
    end
  end

  assign done     = (st == ST_DONE);
  assign rsp_tag  = tag_q;
  assign rsp_data = data_q;
  assign crc_err  = crc_err_q;
  assign timeout  = to_q;
endmodule

// File: rtl/sline_xcvr_chk.sv
module sline_xcvr_chk #(
  parameter int DATA_W   = 32,
  parameter int WAIT_MAX = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              link_dir,
  input logic              timeout,
  input logic              crc_err,
  input logic [1:0]        rsp_tag,
  input logic [DATA_W-1:0] rsp_data,
  input logic              bit_end,
  input logic              in_wait,
  input logic              idle_w
);
  logic [31:0] wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wcnt <= '0;
    else if (!in_wait) wcnt <= '0;
    else if (bit_end)  wcnt <= wcnt + 1'b1;
  end

  assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= 32'(WAIT_MAX));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_dir_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_dir) |-> done);

  assert_timeout_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> (rsp_tag == 2'd0 && !crc_err && rsp_data == '0));

  assert_nodata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_tag != 2'd0) |-> (rsp_data == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && $past(idle_w)) |->
      ($stable(rsp_tag) && $stable(rsp_data) && $stable(crc_err) && $stable(timeout)));
endmodule

bind sline_xcvr sline_xcvr_chk #(.DATA_W(DATA_W), .WAIT_MAX(WAIT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .link_dir(link_dir),
  .timeout(timeout), .crc_err(crc_err), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
  .bit_end(bit_end), .in_wait(in_wait), .idle_w(idle_w)
);

// File: tb/test_sline_xcvr.sv
module test_sline_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int ECHO = 16;
  localparam int WMAX = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] tx_frame = '0;
  logic [6:0]  tx_len = '0;
  logic [2:0]  rx_bytes = '0;
  logic link_clk, link_dat_o, link_dir, done, crc_err, timeout, line;
  logic [1:0]  rsp_tag;
  logic [31:0] rsp_data;
  logic slv_drv = 1'b1;
  logic slv_q[$];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = link_dir ? link_dat_o : slv_drv;

  sline_xcvr i_sline_xcvr (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_frame(tx_frame),
    .tx_len(tx_len), .rx_bytes(rx_bytes), .link_clk(link_clk),
    .link_dat_o(link_dat_o), .link_dat_i(line), .link_dir(link_dir),
    .done(done), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .crc_err(crc_err), .timeout(timeout)
  );

  task automatic chk(input bit ok, input int req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // remainder of msg*x^4 divided by 1_0111 (long division)
  function automatic logic [3:0] div_rem(input longint msg, input int nbits);
    longint v;
    v = msg << 4;
    for (int i = nbits + 3; i >= 4; i--)
      if (v[i]) v = v ^ (longint'(5'b10111) << (i - 4));
    return v[3:0];
  endfunction

  // slave: after each link clock fall while receiving, present next wire level
  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && !link_clk && prev && !link_dir)
        slv_drv = (slv_q.size() > 0) ? slv_q.pop_front() : 1'b1;
      prev = link_clk;
    end
  end

  // expected per-cycle link state: {lclk, dir, dat, done}, with requirement
  logic [3:0] exp_q[$];
  int         req_q[$];

  task automatic push_bit(input logic dir, input logic dat, input int req);
    for (int p = 0; p < 2*HALF; p++) begin
      exp_q.push_back({(p >= HALF), dir, dat, 1'b0});
      req_q.push_back(req);
    end
  endtask

  task automatic run_txn(input logic [63:0] frm, input int len, input int nby,
                         input int dly, input bit respond, input logic [1:0] id,
                         input logic [1:0] tg, input logic [31:0] dv,
                         input bit bad_crc, input int inj);
    longint msg; int nb; logic [3:0] crc; int rxb; bit to;
    logic [31:0] edat; logic [1:0] etag; bit ecrc; int didx;
    msg = 1; nb = 1;
    msg = (msg << 2) | longint'(id);
    msg = (msg << 2) | longint'(tg);
    nb = 5;
    edat = '0;
    if (tg == 2'd0 && nby > 0) begin
      msg = (msg << (nby*8)) | (longint'(dv) & ((longint'(1) << (nby*8)) - 1));
      nb += nby*8;
      edat = 32'(longint'(dv) & ((longint'(1) << (nby*8)) - 1));
    end
    crc = div_rem(msg, nb);
    if (bad_crc) crc[0] = ~crc[0];
    slv_q.delete();
    if (respond) begin
      for (int i = 0; i < dly; i++) slv_q.push_back(1'b1);
      for (int i = nb - 1; i >= 0; i--) slv_q.push_back(~msg[i]);
      for (int i = 3; i >= 0; i--) slv_q.push_back(~crc[i]);
    end
    to = !respond || (dly >= WMAX);
    etag = to ? 2'd0 : tg;
    ecrc = to ? 1'b0 : bad_crc;
    if (to) edat = '0;
    rxb = to ? WMAX : dly + nb + 4;

    exp_q.delete(); req_q.delete();
    push_bit(1'b1, 1'b0, 2);                              // R2 start bit
    for (int i = len - 1; i >= 0; i--) push_bit(1'b1, ~frm[i], 2);
    for (int i = 0; i < ECHO; i++) push_bit(1'b1, 1'b1, 3); // R3
    for (int i = 0; i < rxb; i++) push_bit(1'b0, 1'b1, 4);  // R4
    didx = exp_q.size();
    exp_q.push_back(4'b1111); req_q.push_back(9);           // R9 done
    for (int i = 0; i < 3; i++) begin exp_q.push_back(4'b1110); req_q.push_back(1); end

    @(negedge clk);
    tx_frame = frm; tx_len = 7'(len); rx_bytes = 3'(nby); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < exp_q.size(); k++) begin
      logic [3:0] e; bit ok;
      e = exp_q[k];
      ok = (link_clk == e[3]) && (link_dir == e[2]) && (done == e[0]) &&
           (!e[2] || link_dat_o == e[1]);
      chk(ok, (k < didx) ? req_q[k] : ((inj > 0) ? 10 : req_q[k]),
          $sformatf("link state cycle %0d", k),
          {link_clk, link_dir, link_dat_o, done}, e);
      if (k == didx) begin
        chk(rsp_tag == etag, 6, "tag", rsp_tag, etag);
        chk(rsp_data == edat, 7, "data", rsp_data, edat);
        chk(crc_err == ecrc, 8, "crc_err", crc_err, ecrc);
        chk(timeout == to, 5, "timeout", timeout, to);
      end
      if (inj > 0 && k == inj) begin                       // R10 stray start
        tx_frame = ~frm; tx_len = 7'd5; rx_bytes = 3'd0; start = 1'b1;
      end
      if (inj > 0 && k == inj + 1) start = 1'b0;
      @(negedge clk);
    end
    // R9 results held while idle
    chk(rsp_tag == etag && rsp_data == edat && crc_err == ecrc && timeout == to,
        9, "results held", {rsp_tag, rsp_data, crc_err, timeout},
        {etag, edat, ecrc, to});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(link_clk && link_dir && link_dat_o && !done, 1, "reset link",
        {link_clk, link_dir, link_dat_o, done}, 4'b1110);
    chk(rsp_tag == 0 && rsp_data == 0 && !crc_err && !timeout, 1, "reset results",
        {rsp_tag, rsp_data, crc_err, timeout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(link_clk && link_dir && link_dat_o && !done, 1, "idle link",
        {link_clk, link_dir, link_dat_o, done}, 4'b1110);

    // R2 R6 R7 R8: ack with four data bytes
    run_txn(64'hA5, 8, 4, 3, 1, 2'd2, 2'd0, 32'hDEADBEEF, 0, 0);
    // R7: busy tag with data requested, no data bits taken
    run_txn(64'h1A2B, 13, 1, 0, 1, 2'd1, 2'd1, 32'h55, 0, 0);
    // R7: ack with zero bytes
    run_txn(64'h3, 2, 0, 5, 1, 2'd3, 2'd0, 32'h0, 0, 0);
    // R7: two bytes, R10 stray start mid transaction
    run_txn(64'hC3, 8, 2, 2, 1, 2'd0, 2'd0, 32'hFACE, 0, 10);
    // R8: corrupted CRC bit
    run_txn(64'h7F, 7, 4, 1, 1, 2'd1, 2'd0, 32'h12345678, 1, 0);
    // R11: zero-length frame
    run_txn(64'h0, 0, 1, 0, 1, 2'd0, 2'd2, 32'h0, 0, 0);
    // R5: start bit in the last allowed period
    run_txn(64'h9, 4, 1, WMAX - 1, 1, 2'd1, 2'd0, 32'hA7, 0, 0);
    // R5: silent slave
    run_txn(64'h5, 3, 4, 0, 0, 2'd0, 2'd0, 32'h0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule